// File: doc/BRIEF.md
# Free-Running Timer Counter with Overflow Flag

This block is a free-running up-counter, 16 bits wide by default, with an overflow flag and a maskable interrupt. The counter advances by one on each cycle where an external prescaler tick input is high and the run bit is set. When it passes from all ones to zero, the overflow flag goes high. The flag drives the interrupt line while the interrupt enable bit is set. Software clears the flag by writing a 1 to it. A fast-clear mode also lets any read or write of the count register clear the flag.

A second counting mode returns the counter to zero on the tick after it equals a programmed match value. When that match value is all ones, the counter still wraps to zero but no overflow is flagged. An overflow that occurs while the flag is already set is still seen, and the counter keeps running. A hardware overflow in the same cycle as a software clear leaves the flag set.

The flag is a two-state machine. `FLG_CLEAR` goes to `FLG_PENDING` on an overflow event (transition *raise*). `FLG_PENDING` goes back to `FLG_CLEAR` on a clear request in a cycle with no overflow event (transition *ack*). `FLG_PENDING` stays in place when an overflow and a clear arrive together (transition *hold-on-collision*). Every other case keeps the current state.

Top module: `tick_timer_ovf`

## Requirements
- R1: After reset the count, control (address 1), flag (address 2) and match (address 3) registers all read 0, and `irq` is low.
- R2: The count (address 0) increases by one, modulo 2^CNT_W, on each clock where `tick` is high and control bit 0 (run) is 1. In every other cycle it holds. Writes to address 0 never change it.
- R3: Flag register bit 0 becomes 1 on the clock where the count advances from all ones to zero.
- R4: `irq` is high exactly when flag bit 0 is 1 and control bit 1 (interrupt enable) is 1.
- R5: A write to address 2 with data bit 0 equal to 1 clears the flag. A write with data bit 0 equal to 0 leaves it unchanged.
- R6: With control bit 3 (match-wrap) set, a tick in a cycle where the count equals the match register loads zero instead of incrementing.
- R7: With match-wrap set and the match register all ones, the count still goes from all ones to zero, but the flag is not set.
- R8: With control bit 2 (fast clear) set, a `rd_en` or `wr_en` strobe at address 0 clears the flag. With the bit at 0, such strobes leave the flag unchanged.
- R9: An overflow in the same cycle as any clear request leaves the flag set.
- R10: The counter keeps counting past an overflow while the flag is set, and a later overflow is flagged again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler tick enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 count, 1 control, 2 flag, 3 match |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The two functions that can fall in the same cycle are the hardware overflow that sets the flag and a software clear, either by write-1 or by a fast-clear access to the count. The bench tracks the count in its reference model. When the count reaches all ones, it issues the clearing write in exactly the cycle where the tick carries the count across zero. It then requires the flag to read 1 afterwards, while the model is compared on every clock. A clear in an ordinary cycle is checked as well, to confirm that clears do work outside the collision.

// File: rtl/tov_pkg.sv
package tov_pkg;

    typedef enum logic [1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_FLAG  = 2'd2,
        ADDR_MATCH = 2'd3
    } reg_addr_e;

    // Packed MSB first: bit3 wrap, bit2 fast clear, bit1 irq enable, bit0 run
    typedef struct packed {
        logic wrap_on_match;
        logic fast_clr;
        logic irq_en;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;

endpackage

// File: rtl/tov_regs.sv
module tov_regs
    import tov_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_addr_e        addr,
    input  logic [CNT_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] match_val
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl      <= '0;
            match_val <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_CTRL:  ctrl      <= ctrl_t'(wdata[CTRL_W-1:0]);
                ADDR_MATCH: match_val <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/tov_counter.sv
module tov_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             wrap_on_match,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic advance;
    logic hit_match;
    logic suppress;

    assign advance   = run && tick;
    assign hit_match = wrap_on_match && (count == match_val);
    assign suppress  = wrap_on_match && (match_val == ALL_ONES);
    assign ovf_evt   = advance && (count == ALL_ONES) && !suppress;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (advance) begin
            if (hit_match) count <= '0;
            else           count <= count + 1'b1;
        end
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && tick) |=> $stable(count));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && count == ALL_ONES) |=> (count == '0));

    p_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && wrap_on_match && count == match_val) |=> (count == '0));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_on_match && match_val == ALL_ONES) |-> !ovf_evt);

endmodule

// File: rtl/tov_flag_fsm.sv
module tov_flag_fsm
    import tov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic clr_req,
    output logic flag
);

    flag_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FLG_CLEAR:   if (ovf_evt) state_nx = FLG_PENDING;               // raise
            FLG_PENDING: if (clr_req && !ovf_evt) state_nx = FLG_CLEAR;     // ack; else hold-on-collision
            default:     state_nx = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLG_CLEAR;
        else        state <= state_nx;
    end

    always_comb begin
        flag = 1'b0;
        unique case (state)
            FLG_CLEAR:   flag = 1'b0;
            FLG_PENDING: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flag);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !ovf_evt) |=> !flag);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

endmodule

// File: rtl/tick_timer_ovf.sv
module tick_timer_ovf
    import tov_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);

    reg_addr_e        reg_sel;
    ctrl_t            ctrl;
    logic [CNT_W-1:0] match_val;
    logic [CNT_W-1:0] count;
    logic             ovf_evt;
    logic             flag;
    logic             clr_req;

    assign reg_sel = reg_addr_e'(addr);

    tov_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (reg_sel),
        .wdata     (wdata),
        .ctrl      (ctrl),
        .match_val (match_val)
    );

    tov_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .run           (ctrl.run),
        .wrap_on_match (ctrl.wrap_on_match),
        .match_val     (match_val),
        .count         (count),
        .ovf_evt       (ovf_evt)
    );

    // Clear sources: write-1 to flag, or fast-clear access to the count
    always_comb begin
        clr_req = 1'b0;
        unique case (reg_sel)
            ADDR_FLAG:  clr_req = wr_en && wdata[0];
            ADDR_COUNT: clr_req = ctrl.fast_clr && (wr_en || rd_en);
            default:    clr_req = 1'b0;
        endcase
    end

    tov_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .ovf_evt (ovf_evt),
        .clr_req (clr_req),
        .flag    (flag)
    );

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            ADDR_COUNT: rdata = count;
            ADDR_CTRL:  rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl};
            ADDR_FLAG:  rdata = {{(CNT_W-1){1'b0}}, flag};
            ADDR_MATCH: rdata = match_val;
            default:    rdata = '0;
        endcase
    end

    assign irq = flag && ctrl.irq_en;

    p_irq_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.irq_en |-> !irq);

    p_count_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == ADDR_COUNT && !tick) |=> $stable(count));

endmodule

// File: tb/tick_timer_ovf_test.sv
`timescale 1ns/1ps
module tick_timer_ovf_test;

    localparam int W   = 10;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int m_cnt = 0;
    int m_ctrl = 0;
    int m_match = 0;
    int m_flag = 0;

    always #2 clk = ~clk;

    tick_timer_ovf #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int model_rd(input int a);
        case (a)
            0: return m_cnt;
            1: return m_ctrl;
            2: return m_flag;
            default: return m_match;
        endcase
    endfunction

    // one clock: drive, compare outputs against the model, clock, update model
    task automatic step(input logic w, input logic r, input int a, input int d, input logic t);
        bit run, irqe, fast, wrap, adv, ovf, clr;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = 2'(a); wdata = W'(d); tick = t;
        #1;
        case (a)
            0: check("R2 count", int'(rdata), model_rd(a));
            1: check("R1 ctrl", int'(rdata), model_rd(a));
            2: check("R3 flag", int'(rdata), model_rd(a));
            default: check("R6 match", int'(rdata), model_rd(a));
        endcase
        check("R4 irq", int'(irq), m_flag & ((m_ctrl >> 1) & 1));
        @(posedge clk);
        run  = m_ctrl[0];
        irqe = m_ctrl[1];
        fast = m_ctrl[2];
        wrap = m_ctrl[3];
        adv  = run && t;
        ovf  = adv && (m_cnt == MAX) && !(wrap && m_match == MAX);
        clr  = (w && a == 2 && d[0]) || (fast && (w || r) && a == 0);
        if (ovf)      m_flag = 1;
        else if (clr) m_flag = 0;
        if (adv) m_cnt = (wrap && m_cnt == m_match) ? 0 : (m_cnt + 1) % (MAX + 1);
        if (w && a == 1) m_ctrl = d & 15;
        if (w && a == 3) m_match = d & MAX;
        if (irqe) begin end
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, i % 4, 0, t);
    endtask

    task automatic peek(input int a, output int v);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; addr = 2'(a); tick = 1'b0;
        #1;
        v = int'(rdata);
    endtask

    task automatic run_to_max();
        while (m_cnt != MAX) step(1'b0, 1'b0, 0, 0, 1'b1);
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            peek(a, v);
            check("R1 reset reg", v, 0);
        end
        check("R1 reset irq", int'(irq), 0);

        // R2 counting gated by tick and run
        idle(4, 1'b1);                       // run=0: no count
        peek(0, v); check("R2 hold without run", v, 0);
        step(1'b1, 1'b0, 1, 1, 1'b0);        // run
        for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 0, 0, 1'(i % 3 != 0));
        peek(0, v); check("R2 gated count", v, 8);
        step(1'b1, 1'b0, 0, 77, 1'b0);       // write to count ignored
        peek(0, v); check("R2 count write ignored", v, 8);

        // R3 overflow sets flag; R4 masked irq
        run_to_max();
        step(1'b0, 1'b0, 0, 0, 1'b1);
        peek(2, v); check("R3 flag after wrap", v, 1);
        peek(0, v); check("R3 count wrapped", v, 0);
        check("R4 irq masked", int'(irq), 0);
        step(1'b1, 1'b0, 1, 3, 1'b0);        // irq enable
        #1 check("R4 irq asserted", int'(irq), 1);

        // R8 fast clear off: count access leaves flag
        step(1'b0, 1'b1, 0, 0, 1'b0);
        peek(2, v); check("R8 no fast clear", v, 1);
        // R5 write 0 no effect, write 1 clears
        step(1'b1, 1'b0, 2, 0, 1'b0);
        peek(2, v); check("R5 write0 keeps flag", v, 1);
        step(1'b1, 1'b0, 2, 1, 1'b0);
        peek(2, v); check("R5 write1 clears", v, 0);

        // R10 counter keeps running; second overflow with flag set; R9 collision
        run_to_max();
        step(1'b0, 1'b0, 0, 0, 1'b1);        // overflow 2
        idle(5, 1'b1);
        peek(0, v); check("R10 counting past overflow", v, 5);
        run_to_max();
        step(1'b1, 1'b0, 2, 1, 1'b1);        // clear collides with overflow 3
        peek(2, v); check("R9 set wins over clear", v, 1);
        check("R10 irq still high", int'(irq), 1);

        // R8 fast clear on: read and write of count clear
        step(1'b1, 1'b0, 1, 7, 1'b0);
        step(1'b0, 1'b1, 0, 0, 1'b0);
        peek(2, v); check("R8 fast clear by read", v, 0);
        run_to_max();
        step(1'b0, 1'b1, 0, 0, 1'b1);        // fast clear collides with overflow
        peek(2, v); check("R9 set wins over fast clear", v, 1);
        step(1'b1, 1'b0, 0, 12, 1'b0);
        peek(2, v); check("R8 fast clear by write", v, 0);
        peek(0, v); check("R2 count unchanged by write", v, 0);

        // R6 match wrap
        step(1'b1, 1'b0, 3, 5, 1'b0);
        step(1'b1, 1'b0, 1, 9, 1'b0);        // wrap + run
        idle(6, 1'b1);
        peek(0, v); check("R6 wrapped at match", v, 0);
        idle(3, 1'b1);
        peek(0, v); check("R6 counting after wrap", v, 3);

        // R7 suppression with match all ones
        step(1'b1, 1'b0, 3, MAX, 1'b0);
        run_to_max();
        step(1'b0, 1'b0, 0, 0, 1'b1);
        peek(0, v); check("R7 count wrapped", v, 0);
        peek(2, v); check("R7 no flag", v, 0);
        check("R7 no irq", int'(irq), 0);

        // R10 a later normal overflow flags again
        step(1'b1, 1'b0, 1, 3, 1'b0);
        run_to_max();
        step(1'b0, 1'b0, 0, 0, 1'b1);
        peek(2, v); check("R10 later overflow flagged", v, 1);

        idle(8, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule